// File: doc/BRIEF.md
# Phase-Target Delay Tap Search and Tracking Controller

This block chooses the setting of a 9-bit programmable delay line so that a measured phase between two clock domains settles on a chosen target. An external phase detector delivers one unsigned phase sample per `phase_valid` strobe. In this scale a magnitude of 16 equals 180 degrees. Configuration inputs supply the target magnitude, the slope direction the lock point must lie on, a start tap, lower and upper guard taps, and the width of a keep-out window around zero phase.

A `start` pulse begins a search. The tap is loaded from the start tap, limited to the guard taps, and then rises by one step for each sample. Lock is declared on the first sample where the phase has crossed the target in the requested direction, comparing it with the sample before it, and where the phase lies outside the keep-out window. If the upper guard is reached without a lock, the controller stops and raises `error`. After lock the controller tracks drift. It moves the tap by one step, within the guard taps, only after a run of samples that all miss the target on the same side by two or more.

Top module: `phase_tap_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to idle: `locked` and `error` go to 0 and `tap` takes `cfg_start_tap` (limited to 432).
- R2: In idle, `tap` follows `cfg_start_tap` each cycle. An accepted `start` loads `tap` with `cfg_start_tap` clamped into [effective lower guard, effective upper guard] and begins the search.
- R3: During the search, each `phase_valid` sample that neither locks nor fails raises `tap` by exactly 1 on the next edge. A cycle without `phase_valid` leaves `tap` unchanged.
- R4: With `cfg_slope_neg`=0, lock needs previous sample < target and current sample >= target. With `cfg_slope_neg`=1, it needs previous > target and current <= target. On lock, `locked` goes to 1 and `tap` keeps the value at which the locking sample was taken. The first sample after a start never locks.
- R5: A crossing of the target in the direction opposite to `cfg_slope_neg` does not lock, and the search goes on stepping.
- R6: No lock is declared when the current phase sample is <= `cfg_keepout`.
- R7: A non-locking sample taken with `tap` at the effective upper guard moves the controller to the fail state: `error`=1, `locked`=0, and `tap` held. Further samples do not move `tap`.
- R8: In tracking, let err = phase − target. After `RUN_N` (default 4) consecutive samples with |err| >= 2 and the same sign, `tap` moves by one step on the edge of the last of them. The move is −1 when err > 0 and the slope is positive, or when err < 0 and the slope is negative, and +1 in the other two cases.
- R9: In tracking, a sample with |err| <= 1 causes no step and restarts the run. A sample of the opposite sign starts a new run of length 1.
- R10: A tracking step never takes `tap` below the effective lower guard or above the effective upper guard. A step that would do so leaves `tap` unchanged.
- R11: `start` is accepted in idle, tracking and fail. It clears `locked` and `error` and restarts the search. `start` during a search is ignored, and `tap` does not change.
- R12: `tap` never exceeds 432. An upper guard above 432 acts as 432.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a search |
| phase_valid | input | 1 | Strobe for `phase_meas` |
| phase_meas | input | 5 | Measured phase, unsigned, 16 = 180 degrees |
| cfg_target | input | 5 | Target phase magnitude |
| cfg_slope_neg | input | 1 | 0: lock on rising phase-vs-tap slope, 1: on falling slope |
| cfg_keepout | input | 5 | Phases at or below this value never lock |
| cfg_start_tap | input | 9 | Search start tap |
| cfg_lo_guard | input | 9 | Lowest tap allowed |
| cfg_hi_guard | input | 9 | Highest tap allowed (limited to 432) |
| tap | output | 9 | Delay line tap setting |
| locked | output | 1 | Tracking mode active |
| error | output | 1 | Search ended at the guard without lock |

## Verification
The search is driven with a phase sequence that falls through the target and then rises back onto it. This separates a slope-aware crossing test from a plain equality test, and shows that a start pulse during the search changes nothing. A falling curve with a negative-slope target checks the mirrored crossing rule. A curve that crosses the target only inside the keep-out window checks that lock is refused there and that the guard failure follows. In tracking, steady runs, runs broken by dead-zone samples, and sign reversals separate a true consecutive-run filter from a simple sample counter. A lock at the upper guard and a guard above 432 check the clamping limits.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_TRACK  = 2'd2,
    ST_FAIL   = 2'd3
  } ptt_state_e;

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int clamp_i(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Crossing of the target between two samples in the requested direction.
  function automatic logic crossed(input int prev, input int cur,
                                   input int tgt, input logic neg);
    if (neg) return (prev > tgt) && (cur <= tgt);
    return (prev < tgt) && (cur >= tgt);
  endfunction

  function automatic logic dead_zone(input int err);
    return (err >= -1) && (err <= 1);
  endfunction

  // Raise the tap when phase is high on a falling slope or low on a rising one.
  function automatic logic want_raise(input logic phase_high, input logic neg);
    return phase_high == neg;
  endfunction

endpackage

// File: rtl/ptt_guard.sv
module ptt_guard #(
  parameter int TAP_MAX = 432,
  parameter int TAP_W   = 9
) (
  input  logic [TAP_W-1:0] lo_in,
  input  logic [TAP_W-1:0] hi_in,
  input  logic [TAP_W-1:0] start_in,
  output logic [TAP_W-1:0] lo_eff,
  output logic [TAP_W-1:0] hi_eff,
  output logic [TAP_W-1:0] start_eff,
  output logic [TAP_W-1:0] idle_tap
);
  import ptt_pkg::*;

  int hi_i, lo_i;

  always_comb begin
    hi_i      = min_i(int'(hi_in), TAP_MAX);
    lo_i      = min_i(int'(lo_in), hi_i);
    hi_eff    = TAP_W'(hi_i);
    lo_eff    = TAP_W'(lo_i);
    start_eff = TAP_W'(clamp_i(int'(start_in), lo_i, hi_i));
    idle_tap  = TAP_W'(min_i(int'(start_in), TAP_MAX));
  end

endmodule

// File: rtl/ptt_cross_detect.sv
module ptt_cross_detect #(
  parameter int PH_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            sample_en,
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W-1:0] target,
  input  logic [PH_W-1:0] keepout,
  input  logic            slope_neg,
  output logic            hit
);
  import ptt_pkg::*;

  logic [PH_W-1:0] prev_q;
  logic            have_q;

  always_comb begin
    hit = sample_en && have_q && (phase > keepout) &&
          crossed(int'(prev_q), int'(phase), int'(target), slope_neg);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (sample_en) begin
      prev_q <= phase;
      have_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ptt_drift_filter.sv
module ptt_drift_filter #(
  parameter int PH_W  = 5,
  parameter int RUN_N = 4,
  parameter int CNT_W = $clog2(RUN_N + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            sample_en,
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W-1:0] target,
  input  logic            slope_neg,
  output logic            in_dead,
  output logic            step_up,
  output logic            step_dn
);
  import ptt_pkg::*;

  logic [CNT_W-1:0] run_q;
  logic             last_high_q;
  int               err;
  int               run_next;
  logic             phase_high;
  logic             fire;

  always_comb begin
    err        = int'(phase) - int'(target);
    in_dead    = dead_zone(err);
    phase_high = err > 0;
    run_next   = ((run_q != '0) && (phase_high == last_high_q)) ? int'(run_q) + 1 : 1;
    fire       = sample_en && !in_dead && (run_next >= RUN_N);
    step_up    = fire && want_raise(phase_high, slope_neg);
    step_dn    = fire && !want_raise(phase_high, slope_neg);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_q       <= '0;
      last_high_q <= 1'b0;
    end else if (sample_en) begin
      if (in_dead || fire) run_q <= '0;
      else                 run_q <= CNT_W'(run_next);
      last_high_q <= phase_high;
    end
  end

endmodule

// File: rtl/phase_tap_tracker.sv
module phase_tap_tracker #(
  parameter int TAP_MAX = 432,
  parameter int TAP_W   = $clog2(TAP_MAX + 1),
  parameter int PH_W    = 5,
  parameter int RUN_N   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             phase_valid,
  input  logic [PH_W-1:0]  phase_meas,
  input  logic [PH_W-1:0]  cfg_target,
  input  logic             cfg_slope_neg,
  input  logic [PH_W-1:0]  cfg_keepout,
  input  logic [TAP_W-1:0] cfg_start_tap,
  input  logic [TAP_W-1:0] cfg_lo_guard,
  input  logic [TAP_W-1:0] cfg_hi_guard,
  output logic [TAP_W-1:0] tap,
  output logic             locked,
  output logic             error
);
  import ptt_pkg::*;

  localparam int CNT_W = $clog2(RUN_N + 1);

  ptt_state_e       state_q;
  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] lo_eff, hi_eff, start_eff, idle_tap;

  // Named events, also used by the checker.
  logic start_acc, search_smp, track_smp, at_top;
  logic lock_evt, fail_evt, search_step;
  logic hit, in_dead, trk_up, trk_dn;

  ptt_guard #(.TAP_MAX(TAP_MAX), .TAP_W(TAP_W)) u_guard (
    .lo_in(cfg_lo_guard), .hi_in(cfg_hi_guard), .start_in(cfg_start_tap),
    .lo_eff(lo_eff), .hi_eff(hi_eff), .start_eff(start_eff), .idle_tap(idle_tap)
  );

  always_comb begin
    start_acc   = start && (state_q != ST_SEARCH);
    search_smp  = (state_q == ST_SEARCH) && phase_valid;
    track_smp   = (state_q == ST_TRACK) && phase_valid && !start;
    at_top      = int'(tap_q) >= int'(hi_eff);
    lock_evt    = search_smp && hit;
    fail_evt    = search_smp && !hit && at_top;
    search_step = search_smp && !hit && !at_top;
  end

  ptt_cross_detect #(.PH_W(PH_W)) u_cross (
    .clk(clk), .rst(rst), .clear(start_acc), .sample_en(search_smp),
    .phase(phase_meas), .target(cfg_target), .keepout(cfg_keepout),
    .slope_neg(cfg_slope_neg), .hit(hit)
  );

  ptt_drift_filter #(.PH_W(PH_W), .RUN_N(RUN_N), .CNT_W(CNT_W)) u_drift (
    .clk(clk), .rst(rst), .clear(start_acc), .sample_en(track_smp),
    .phase(phase_meas), .target(cfg_target), .slope_neg(cfg_slope_neg),
    .in_dead(in_dead), .step_up(trk_up), .step_dn(trk_dn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tap_q   <= idle_tap;
    end else if (start_acc) begin
      state_q <= ST_SEARCH;
      tap_q   <= start_eff;
    end else begin
      case (state_q)
        ST_IDLE:   tap_q <= idle_tap;
        ST_SEARCH: begin
          if (lock_evt)         state_q <= ST_TRACK;
          else if (fail_evt)    state_q <= ST_FAIL;
          else if (search_step) tap_q   <= tap_q + 1'b1;
        end
        ST_TRACK: begin
          if (trk_up && (int'(tap_q) < int'(hi_eff)))      tap_q <= tap_q + 1'b1;
          else if (trk_dn && (int'(tap_q) > int'(lo_eff))) tap_q <= tap_q - 1'b1;
        end
        default:   tap_q <= tap_q;
      endcase
    end
  end

  assign tap    = tap_q;
  assign locked = (state_q == ST_TRACK);
  assign error  = (state_q == ST_FAIL);

endmodule

// File: rtl/ptt_checks.sv
module ptt_checks #(
  parameter int TAP_MAX = 432,
  parameter int TAP_W   = 9,
  parameter int PH_W    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             phase_valid,
  input logic [PH_W-1:0]  phase_meas,
  input logic [PH_W-1:0]  cfg_keepout,
  input logic [TAP_W-1:0] tap,
  input logic             locked,
  input logic             error,
  input logic             search_step,
  input logic             lock_evt,
  input logic             fail_evt,
  input logic             in_dead,
  input logic             track_smp
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!locked && !error));

  p_search_step_r3: assert property (@(posedge clk) disable iff (rst)
    search_step |=> (tap == $past(tap) + 1'b1));

  p_lock_on_valid_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(phase_valid) && $stable(tap)));

  p_no_keepout_lock_r6: assert property (@(posedge clk) disable iff (rst)
    lock_evt |-> (phase_meas > cfg_keepout));

  p_fail_holds_r7: assert property (@(posedge clk) disable iff (rst)
    fail_evt |=> (error && !locked && $stable(tap)));

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(locked && error));

  p_track_one_step_r8: assert property (@(posedge clk) disable iff (rst)
    (locked && !start) |=> ((tap == $past(tap)) || (tap == $past(tap) + 1'b1) ||
                            (tap + 1'b1 == $past(tap))));

  p_dead_zone_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (track_smp && in_dead) |=> $stable(tap));

  p_tap_ceiling_r12: assert property (@(posedge clk) disable iff (rst)
    int'(tap) <= TAP_MAX);

endmodule

bind phase_tap_tracker ptt_checks #(.TAP_MAX(TAP_MAX), .TAP_W(TAP_W), .PH_W(PH_W)) u_ptt_checks (
  .clk(clk), .rst(rst), .start(start), .phase_valid(phase_valid),
  .phase_meas(phase_meas), .cfg_keepout(cfg_keepout), .tap(tap),
  .locked(locked), .error(error), .search_step(search_step),
  .lock_evt(lock_evt), .fail_evt(fail_evt), .in_dead(in_dead),
  .track_smp(track_smp)
);

// File: tb/phase_tap_tracker_bench.sv
module phase_tap_tracker_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       phase_valid = 1'b0;
  logic [4:0] phase_meas = '0;
  logic [4:0] cfg_target = 5'd6;
  logic       cfg_slope_neg = 1'b0;
  logic [4:0] cfg_keepout = 5'd2;
  logic [8:0] cfg_start_tap = 9'd20;
  logic [8:0] cfg_lo_guard = 9'd10;
  logic [8:0] cfg_hi_guard = 9'd60;
  logic [8:0] tap;
  logic       locked, error;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  typedef struct {
    int    due;
    int    tap;
    bit    lk;
    bit    er;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phase_tap_tracker u_phase_tap_tracker (
    .clk(clk), .rst(rst), .start(start), .phase_valid(phase_valid),
    .phase_meas(phase_meas), .cfg_target(cfg_target), .cfg_slope_neg(cfg_slope_neg),
    .cfg_keepout(cfg_keepout), .cfg_start_tap(cfg_start_tap),
    .cfg_lo_guard(cfg_lo_guard), .cfg_hi_guard(cfg_hi_guard),
    .tap(tap), .locked(locked), .error(error)
  );

  // Driver: one cycle of stimulus plus the expected outputs after its edge.
  task automatic drive(input bit st, input bit vl, input int ph,
                       input int etap, input bit elk, input bit eer, input string tag);
    exp_t e;
    @(negedge clk);
    start       = st;
    phase_valid = vl;
    phase_meas  = 5'(ph);
    e.due = cyc + 1; e.tap = etap; e.lk = elk; e.er = eer; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1;
    start       = 1'b0;
    phase_valid = 1'b0;
  endtask

  task automatic samp(input int ph, input int etap, input bit elk, input bit eer,
                      input string tag);
    drive(1'b0, 1'b1, ph, etap, elk, eer, tag);
  endtask

  // Monitor: compare scoreboard items once their edge has passed.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        n_tests++;
        if (int'(tap) != e.tap || locked != e.lk || error != e.er) begin
          n_fail++;
          $display("FAIL %s: tap=%0d locked=%0b error=%0b expected tap=%0d locked=%0b error=%0b",
                   e.tag, tap, locked, error, e.tap, e.lk, e.er);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    drive(0, 0, 0, 20, 0, 0, "R1 reset state");
    cfg_start_tap = 9'd25;
    drive(0, 0, 0, 25, 0, 0, "R2 idle follows start tap");
    cfg_start_tap = 9'd20;
    drive(1, 0, 0, 20, 0, 0, "R2 start loads start tap");
    drive(0, 0, 0, 20, 0, 0, "R3 no valid no step");

    // Rising-slope target 6: phase falls through 6 first (wrong slope).
    samp(8, 21, 0, 0, "R4 first sample never locks");
    samp(7, 22, 0, 0, "R3 step per sample");
    samp(6, 23, 0, 0, "R5 falling through target no lock");
    samp(5, 24, 0, 0, "R5 still searching");
    drive(1, 0, 0, 24, 0, 0, "R11 start ignored in search");
    samp(6, 24, 1, 0, "R4 rising crossing locks");

    // Tracking.
    samp(9, 24, 1, 0, "R8 run 1");
    samp(9, 24, 1, 0, "R8 run 2");
    samp(9, 24, 1, 0, "R8 run 3");
    samp(9, 23, 1, 0, "R8 run 4 steps down");
    samp(7, 23, 1, 0, "R9 dead zone +1");
    samp(5, 23, 1, 0, "R9 dead zone -1");
    samp(6, 23, 1, 0, "R9 dead zone 0");
    samp(9, 23, 1, 0, "R9 run a1");
    samp(9, 23, 1, 0, "R9 run a2");
    samp(9, 23, 1, 0, "R9 run a3");
    samp(7, 23, 1, 0, "R9 dead sample breaks run");
    samp(9, 23, 1, 0, "R9 run b1");
    samp(9, 23, 1, 0, "R9 run b2");
    samp(9, 23, 1, 0, "R9 run b3 no step");
    samp(3, 23, 1, 0, "R9 sign change restarts run");
    samp(3, 23, 1, 0, "R8 low run 2");
    samp(3, 23, 1, 0, "R8 low run 3");
    samp(3, 24, 1, 0, "R8 low run 4 steps up");

    // Keep-out: target 2 with keep-out 2, then guard failure.
    cfg_target = 5'd2; cfg_start_tap = 9'd40; cfg_hi_guard = 9'd43;
    drive(1, 0, 0, 40, 0, 0, "R11 restart from tracking");
    samp(1, 41, 0, 0, "R6 below keep-out");
    samp(2, 42, 0, 0, "R6 crossing inside keep-out refused");
    samp(3, 43, 0, 0, "R6 search continues");
    samp(4, 43, 0, 1, "R7 guard reached fail");
    samp(9, 43, 0, 1, "R7 fail holds tap");

    // Falling-slope target 6, lock at the upper guard.
    cfg_target = 5'd6; cfg_slope_neg = 1'b1; cfg_start_tap = 9'd58; cfg_hi_guard = 9'd60;
    drive(1, 0, 0, 58, 0, 0, "R11 restart from fail clears error");
    samp(9, 59, 0, 0, "R3 step");
    samp(7, 60, 0, 0, "R4 not yet crossed");
    samp(5, 60, 1, 0, "R4 falling crossing locks at guard");
    samp(10, 60, 1, 0, "R10 run 1");
    samp(10, 60, 1, 0, "R10 run 2");
    samp(10, 60, 1, 0, "R10 run 3");
    samp(10, 60, 1, 0, "R10 raise clamped at upper guard");
    samp(2, 60, 1, 0, "R8 neg run 1");
    samp(2, 60, 1, 0, "R8 neg run 2");
    samp(2, 60, 1, 0, "R8 neg run 3");
    samp(2, 59, 1, 0, "R8 falling slope low phase lowers tap");

    // Upper guard beyond the legal range.
    cfg_slope_neg = 1'b0; cfg_start_tap = 9'd430; cfg_hi_guard = 9'd500;
    drive(1, 0, 0, 430, 0, 0, "R12 start near top");
    samp(1, 431, 0, 0, "R12 step");
    samp(1, 432, 0, 0, "R12 step to 432");
    samp(1, 432, 0, 1, "R12 fail at 432");

    // Start tap below the lower guard.
    cfg_start_tap = 9'd5; cfg_lo_guard = 9'd10; cfg_hi_guard = 9'd60;
    drive(1, 0, 0, 10, 0, 0, "R2 start clamped to lower guard");
    drive(0, 0, 0, 10, 0, 0, "R11 error cleared by start");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule